// File: doc/BRIEF.md
# Warm Reset Sequencer with Cold-Reset Fallback

This block runs a warm reset of an application processor through its power-management controller, and it watches the processor's reset handshake afterwards. A one-cycle command starts the sequence. The block drives the controller's reset-input line low for a fixed number of timebase ticks and then releases it. It then waits a bounded number of ticks for the processor reset line to go low. If that line does not go low in time, the block raises a one-cycle cold-reset request, which the surrounding power logic turns into a full off/on cycle.

A second state machine runs on its own and watches the processor reset line after a two-flop synchroniser. While the system reports that it is on or suspended, it counts low-to-high transitions of that line. When the count reaches the expected number, it emits a reset-complete strobe straight away. With fewer transitions, the strobe fires once no further transition has arrived for a quiet interval. A mismatch flag travels with the strobe when the count was not the expected one. All delays are counted in ticks of a shared millisecond timebase.

The pulse machine has four states. `P_IDLE` goes to `P_DRIVE` when the command arrives. `P_DRIVE` goes to `P_WAIT` once the pulse length has elapsed. `P_WAIT` goes back to `P_IDLE` when the processor reset line is seen low, and goes to `P_FAIL` when the response window expires. `P_FAIL` goes back to `P_IDLE` after one cycle. The edge machine has three states. `E_IDLE` goes to `E_COUNT` on the first counted transition. `E_COUNT` goes to `E_NOTIFY` when the count reaches its target or the quiet timer expires. `E_NOTIFY` goes back to `E_IDLE` after one cycle and clears the count.

Top module: `warm_reset_ctl`

## Requirements
- R1: After reset, `resin_n` is 1 and `cold_req`, `rst_done` and `cnt_mismatch` are 0. A `warm_req` in `P_IDLE` drives `resin_n` low for exactly `PULSE_TICKS` tick cycles and then releases it to 1.
- R2: After release, if the synchronised `cpu_rst_n` is not seen at 0 within `RESP_TICKS` ticks, `cold_req` is 1 for one cycle.
- R3: If `cpu_rst_n` goes to 0 inside the response window, no `cold_req` is produced for that sequence.
- R4: A `warm_req` that arrives while the pulse is being driven or while the response window is open has no effect: the pulse is not lengthened and no second sequence follows.
- R5: Only 0-to-1 transitions of `cpu_rst_n` that are detected while `sys_active` is 1 are counted. Transitions detected while `sys_active` is 0 never lead to `rst_done`.
- R6: When the counted transitions reach `EXPECT_EDGES` (default 3), `rst_done` fires at once with `cnt_mismatch` at 0.
- R7: With fewer than `EXPECT_EDGES` transitions, each transition restarts a quiet timer. `rst_done` fires with `cnt_mismatch` at 1 after `QUIET_TICKS` ticks without a new transition.
- R8: After `rst_done` the count returns to zero, so the next group of transitions is counted from scratch.
- R9: `cpu_rst_n` passes through two synchroniser flops. A transition that completes the expected count shows as `rst_done` at 1 exactly three clock edges after the input changes.
- R10: `cold_req` and `rst_done` are single-cycle strobes, and `cnt_mismatch` is 1 only in a cycle where `rst_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe (one per millisecond) |
| warm_req | input | 1 | One-cycle warm reset command |
| cpu_rst_n | input | 1 | Processor reset line, asynchronous, low means asserted |
| sys_active | input | 1 | 1 while the system is on or suspended |
| resin_n | output | 1 | Reset-input line to the power controller, active low |
| cold_req | output | 1 | One-cycle cold-reset request |
| rst_done | output | 1 | One-cycle reset-complete notification |
| cnt_mismatch | output | 1 | With `rst_done`: transition count differed from the expected value |

## Verification
If the pulse machine holds a wrong state, the `resin_n` width is wrong or a stray `cold_req` appears. The bench sees this within one pulse length plus one response window, because it counts ticks against both port edges. If the edge machine holds a stale count, a later group of three transitions gives a mismatch, or a notification at the wrong time. The exact three-edge latency shows whether a synchroniser stage is missing or extra. Transitions seen while the system is inactive must produce no strobe for a whole quiet interval.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_DRIVE = 2'd1,
        P_WAIT  = 2'd2,
        P_FAIL  = 2'd3
    } pulse_st_t;

    typedef enum logic [1:0] {
        E_IDLE   = 2'd0,
        E_COUNT  = 2'd1,
        E_NOTIFY = 2'd2
    } edge_st_t;

endpackage

// File: rtl/wrp_sync.sv
module wrp_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wrp_pulser.sv
module wrp_pulser
    import wrp_pkg::*;
#(
    parameter int PULSE_TICKS = 20,
    parameter int RESP_TICKS  = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic warm_req,
    input  logic line_low,
    output logic resin_n,
    output logic cold_req
);
    localparam int MAXT = (PULSE_TICKS > RESP_TICKS) ? PULSE_TICKS : RESP_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    pulse_st_t st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            P_IDLE: begin
                if (warm_req) begin
                    st_n  = P_DRIVE;
                    cnt_n = '0;
                end
            end
            P_DRIVE: begin
                if (tick) begin
                    if (cnt == CW'(PULSE_TICKS - 1)) begin
                        st_n  = P_WAIT;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            P_WAIT: begin
                if (line_low) begin
                    st_n = P_IDLE;
                end else if (tick) begin
                    if (cnt == CW'(RESP_TICKS - 1)) st_n = P_FAIL;
                    else                            cnt_n = cnt + 1'b1;
                end
            end
            P_FAIL: begin
                st_n  = P_IDLE;
                cnt_n = '0;
            end
            default: st_n = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= P_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        resin_n  = (st != P_DRIVE);
        cold_req = (st == P_FAIL);
    end
endmodule

// File: rtl/wrp_edge_tracker.sv
module wrp_edge_tracker
    import wrp_pkg::*;
#(
    parameter int EXPECT_EDGES = 3,
    parameter int QUIET_TICKS  = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_sync,
    input  logic sys_active,
    output logic rst_done,
    output logic cnt_mismatch
);
    localparam int EW = $clog2(EXPECT_EDGES + 1);
    localparam int TW = $clog2(QUIET_TICKS + 1);

    edge_st_t st, st_n;
    logic [EW-1:0] ecnt, ecnt_n;
    logic [TW-1:0] tmr, tmr_n;
    logic          line_prev;
    logic          rise_ok;

    assign rise_ok = line_sync & ~line_prev & sys_active;

    always_comb begin
        st_n   = st;
        ecnt_n = ecnt;
        tmr_n  = tmr;
        unique case (st)
            E_IDLE: begin
                if (rise_ok) begin
                    ecnt_n = EW'(1);
                    tmr_n  = '0;
                    st_n   = (EXPECT_EDGES <= 1) ? E_NOTIFY : E_COUNT;
                end
            end
            E_COUNT: begin
                if (rise_ok) begin
                    ecnt_n = ecnt + 1'b1;
                    tmr_n  = '0;
                    if (ecnt == EW'(EXPECT_EDGES - 1)) st_n = E_NOTIFY;
                end else if (tick) begin
                    if (tmr == TW'(QUIET_TICKS - 1)) st_n = E_NOTIFY;
                    else                             tmr_n = tmr + 1'b1;
                end
            end
            E_NOTIFY: begin
                st_n   = E_IDLE;
                ecnt_n = '0;
                tmr_n  = '0;
            end
            default: st_n = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= E_IDLE;
            ecnt      <= '0;
            tmr       <= '0;
            line_prev <= 1'b1;
        end else begin
            st        <= st_n;
            ecnt      <= ecnt_n;
            tmr       <= tmr_n;
            line_prev <= line_sync;
        end
    end

    always_comb begin
        rst_done     = (st == E_NOTIFY);
        cnt_mismatch = (st == E_NOTIFY) && (ecnt != EW'(EXPECT_EDGES));
    end
endmodule

// File: rtl/warm_reset_ctl.sv
module warm_reset_ctl #(
    parameter int PULSE_TICKS  = 20,
    parameter int RESP_TICKS   = 350,
    parameter int QUIET_TICKS  = 450,
    parameter int EXPECT_EDGES = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic warm_req,
    input  logic cpu_rst_n,
    input  logic sys_active,
    output logic resin_n,
    output logic cold_req,
    output logic rst_done,
    output logic cnt_mismatch
);
    logic line_sync;

    wrp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cpu_rst_n),
        .q_sync  (line_sync)
    );

    wrp_pulser #(.PULSE_TICKS(PULSE_TICKS), .RESP_TICKS(RESP_TICKS)) u_pulser (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .warm_req (warm_req),
        .line_low (~line_sync),
        .resin_n  (resin_n),
        .cold_req (cold_req)
    );

    wrp_edge_tracker #(.EXPECT_EDGES(EXPECT_EDGES), .QUIET_TICKS(QUIET_TICKS)) u_edges (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .line_sync    (line_sync),
        .sys_active   (sys_active),
        .rst_done     (rst_done),
        .cnt_mismatch (cnt_mismatch)
    );
endmodule

// File: rtl/warm_reset_ctl_chk.sv
module warm_reset_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic warm_req,
    input logic resin_n,
    input logic cold_req,
    input logic rst_done,
    input logic cnt_mismatch
);
    // R1
    resin_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resin_n) |-> $past(warm_req));

    // R2
    cold_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_req |-> resin_n);

    // R10
    cold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_req |=> !cold_req);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> !rst_done);

    // R7
    mismatch_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_mismatch |-> rst_done);
endmodule

bind warm_reset_ctl warm_reset_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .warm_req     (warm_req),
    .resin_n      (resin_n),
    .cold_req     (cold_req),
    .rst_done     (rst_done),
    .cnt_mismatch (cnt_mismatch)
);

// File: tb/sim_warm_reset_ctl.sv
`timescale 1ns/1ps
module sim_warm_reset_ctl;
    localparam int PULSE  = 20;
    localparam int RESP   = 350;
    localparam int QUIET  = 450;
    localparam int EXPECT = 3;

    typedef enum int { K_COLD, K_OK, K_MISM } kind_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic warm_req = 1'b0;
    logic cpu_rst_n = 1'b1;
    logic sys_active = 1'b0;
    logic resin_n, cold_req, rst_done, cnt_mismatch;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tick_total = 0;
    int low_ticks = 0;
    int wait_ticks = 0;
    bit meas_on = 1'b0;
    int cold_cnt = 0;
    int done_cnt = 0;
    int done_tick = 0;
    kind_t expq[$];

    always #5 clk = ~clk;

    warm_reset_ctl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .warm_req(warm_req),
        .cpu_rst_n(cpu_rst_n), .sys_active(sys_active), .resin_n(resin_n),
        .cold_req(cold_req), .rst_done(rst_done), .cnt_mismatch(cnt_mismatch)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic score(input kind_t got, input string req);
        if (expq.size() == 0) begin
            check(1'b0, req, int'(got), -1);
        end else begin
            kind_t e;
            e = expq.pop_front();
            check(got == e, req, int'(got), int'(e));
        end
    endtask

    // tick generator, pulse measurement and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cold_req) begin
                cold_cnt++;
                score(K_COLD, "R2");
            end
            if (rst_done) begin
                done_cnt++;
                done_tick = tick_total;
                score(cnt_mismatch ? K_MISM : K_OK, "R7");
            end
        end
        tick = (cyc % 4 == 3);
        cyc++;
        if (tick) begin
            tick_total++;
            if (!resin_n) low_ticks++;
            if (meas_on && resin_n && !cold_req) wait_ticks++;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fire_warm();
        @(negedge clk);
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
    endtask

    task automatic rise();
        @(negedge clk);
        cpu_rst_n = 1'b0;
        cycles(5);
        cpu_rst_n = 1'b1;
    endtask

    initial begin
        cycles(5);
        // R1 reset state
        check(resin_n == 1'b1, "R1", resin_n, 1);
        check(cold_req == 1'b0 && rst_done == 1'b0 && cnt_mismatch == 1'b0,
              "R1", cold_req | rst_done | cnt_mismatch, 0);
        rst_n = 1'b1;
        cycles(3);

        // R1 / R2: pulse length and no-response fallback
        low_ticks = 0; wait_ticks = 0;
        expq.push_back(K_COLD);
        fire_warm();
        @(negedge clk);
        check(resin_n == 1'b0, "R1", resin_n, 0);
        meas_on = 1'b1;
        while (cold_cnt == 0) @(negedge clk);
        meas_on = 1'b0;
        check(low_ticks == PULSE, "R1", low_ticks, PULSE);
        check(wait_ticks == RESP, "R2", wait_ticks, RESP);
        check(resin_n == 1'b1, "R1", resin_n, 1);

        // R4: repeated command during pulse is ignored
        low_ticks = 0;
        expq.push_back(K_COLD);
        fire_warm();
        cycles(10);
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
        while (cold_cnt == 1) @(negedge clk);
        check(low_ticks == PULSE, "R4", low_ticks, PULSE);
        cycles((PULSE + RESP + 5) * 4);
        check(cold_cnt == 2, "R4", cold_cnt, 2);

        // R3: response inside the window suppresses the fallback
        fire_warm();
        while (resin_n == 1'b0) @(negedge clk);
        cycles(40);
        cpu_rst_n = 1'b0;
        cycles((RESP + 5) * 4);
        check(cold_cnt == 2, "R3", cold_cnt, 2);
        cpu_rst_n = 1'b1;
        cycles(10);

        // R5: transitions while inactive are not counted
        for (int i = 0; i < EXPECT; i++) rise();
        cycles((QUIET + 5) * 4);
        check(done_cnt == 0, "R5", done_cnt, 0);

        // R6 / R9: full count, exact latency
        sys_active = 1'b1;
        expq.push_back(K_OK);
        rise(); cycles(10);
        rise(); cycles(10);
        rise();
        cycles(2);
        check(rst_done == 1'b0, "R9", rst_done, 0);
        @(negedge clk);
        check(rst_done == 1'b1, "R9", rst_done, 1);
        check(cnt_mismatch == 1'b0, "R6", cnt_mismatch, 0);
        cycles(2);
        check(done_cnt == 1, "R6", done_cnt, 1);

        // R7: short count notifies after the quiet interval
        begin
            int t0;
            expq.push_back(K_MISM);
            rise(); cycles(40);
            rise();
            t0 = tick_total;
            while (done_cnt == 1) @(negedge clk);
            check(done_tick - t0 >= QUIET && done_tick - t0 <= QUIET + 2,
                  "R7", done_tick - t0, QUIET);
        end

        // R8: count restarts from zero after a notification
        expq.push_back(K_OK);
        rise(); cycles(10);
        rise(); cycles(10);
        rise();
        cycles(4);
        check(done_cnt == 3, "R8", done_cnt, 3);
        cycles(10);

        // R10: no pending or stray strobes
        check(expq.size() == 0, "R10", expq.size(), 0);
        check(resin_n == 1'b1 && cold_req == 1'b0, "R10", resin_n, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule